// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block sits between a small register bus and an on-chip analog-to-digital converter. Software writes one 8-bit control register to pick an input channel, choose single or repeating conversion, select the reference level and decide whether the reference pin is driven. A start bit begins a conversion. An internal down-counter stands in for the converter's latency. When a result is due, the block copies the 10-bit sample present on its input into a result register and pulses a done strobe for one cycle.

The first result after a start always takes the full first-result latency. In repeating mode, later results follow at a much shorter fixed period until software clears the repeat bit. The high bit of the reference selection lives in a neighbouring register and arrives on an input pin. The block combines it with its own low bit to drive a decoded reference-level output.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The register map is: address 0 is the control register; address 1 reads result[7:0]; address 2 reads {6'b0, result[9:8]}; address 3 reads 0. Control bit 7 is start/busy, bit 6 is the low reference-select bit, bit 5 is the reference-pin drive enable, bit 4 is repeat mode, and bits 3:0 are the channel. Bits 6:0 read back the last value written.
- R2: After reset, every control bit, the result register, the done strobe and the latched channel are 0.
- R3: A write with bit 7 set to address 0 is a start. `done_o` rises exactly 5129 clock edges after the start edge and stays high for one cycle. At that same edge the result register loads `samp_i`, and at no other time does it change.
- R4: Control bit 7 reads 1 from the start edge until the completing edge. At a single-shot completion it reads 0.
- R5: A start during a running conversion restarts it. The pending completion is dropped, and the next result comes 5129 edges after the new start.
- R6: Writing 0 to bit 7 does not stop or delay a running conversion. Bits 6:0 still take the written value.
- R7: `ref_lvl_o` is {`ref_hi_i`, bit 6}: 00 means external reference, 01 means 1.0 V and 10 means 2.0 V. Code 11 is reserved and drives 10. `ref_int_en_o` is 1 whenever `ref_lvl_o` is not 00.
- R8: `ref_pin_own_o` equals control bit 5. When it is 1, the buffered reference drives the pin. When it is 0, the pin is free for general-purpose use.
- R9: `chan_o` takes the value of bits 3:0 from the starting write. Later writes without a start leave it unchanged.
- R10: With bit 4 set, the first result comes 5129 edges after the start and later results every 256 edges, while bit 7 stays 1. Once bit 4 is cleared, the next due result is the last one, and bit 7 then reads 0.
- R11: If a start lands on the same edge as a due completion, the restart wins. No done pulse is produced, and the result register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ref_hi_i | input | 1 | High reference-select bit from the neighbouring register |
| samp_i | input | 10 | Converter sample captured when a result is due |
| chan_o | output | 4 | Channel latched at the last start |
| busy_o | output | 1 | Conversion running |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 10 | Result register |
| ref_lvl_o | output | 2 | Decoded reference level |
| ref_int_en_o | output | 1 | Internal reference active |
| ref_pin_own_o | output | 1 | Reference pin driven by the block |

## Verification
Two functions can land on the same edge: a software restart and the counter reaching a due completion. The bench provokes this by timing a start write so that its clock edge is the completion edge. It then requires that no done pulse appears, that the result register keeps its earlier value, and that the next done arrives a full first-result latency later with the new sample. A second overlap comes from clearing the repeat bit one edge after a periodic update. The bench checks that exactly one more update follows, 256 edges after the previous one, and that the busy bit then drops.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int unsigned BUS_AW = 2;
   localparam int unsigned BUS_DW = 8;

   localparam logic [BUS_AW-1:0] ADDR_CTRL   = 2'd0;
   localparam logic [BUS_AW-1:0] ADDR_RES_LO = 2'd1;
   localparam logic [BUS_AW-1:0] ADDR_RES_HI = 2'd2;

   localparam int unsigned START_BIT = 7;

   typedef enum logic [1:0] {
      REF_EXTERNAL = 2'b00,
      REF_1V0      = 2'b01,
      REF_2V0      = 2'b10
   } ref_lvl_e;

   // control bits 6:0, in bus bit order
   typedef struct packed {
      logic       ref_lo;
      logic       pin_drive;
      logic       repeat_en;
      logic [3:0] chan;
   } ctrl_fields_t;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BUS_AW-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [BUS_DW-1:0]   bus_wdata,
   output logic [BUS_DW-1:0]   bus_rdata,
   input  logic                busy_i,
   input  logic [SAMPLE_W-1:0] result_i,
   output ctrl_fields_t        ctrl_o,
   output logic                start_o,
   output logic [3:0]          chan_run_o
);

   localparam int unsigned CTRL_W = $bits(ctrl_fields_t);

   generate
      if (SAMPLE_W < 1 || SAMPLE_W > 2*BUS_DW) begin : g_bad_width
         $error("adc_seq_regs: SAMPLE_W must be 1..16");
      end
   endgenerate

   ctrl_fields_t ctrl_q;
   logic [3:0]   chan_run_q;
   logic         ctrl_wr;
   logic [BUS_DW-1:0] lo_byte, hi_byte;

   assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
   assign start_o = ctrl_wr && bus_wdata[START_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         chan_run_q <= '0;
      end else begin
         if (ctrl_wr) ctrl_q <= ctrl_fields_t'(bus_wdata[CTRL_W-1:0]);
         if (start_o) chan_run_q <= bus_wdata[3:0];
      end
   end

   generate
      if (SAMPLE_W > BUS_DW) begin : g_two_bytes
         always_comb begin
            lo_byte = result_i[BUS_DW-1:0];
            hi_byte = '0;
            hi_byte[SAMPLE_W-BUS_DW-1:0] = result_i[SAMPLE_W-1:BUS_DW];
         end
      end else begin : g_one_byte
         always_comb begin
            lo_byte = '0;
            lo_byte[SAMPLE_W-1:0] = result_i;
            hi_byte = '0;
         end
      end
   endgenerate

   always_comb begin
      unique case (bus_addr)
         ADDR_CTRL:   bus_rdata = {busy_i, ctrl_q};
         ADDR_RES_LO: bus_rdata = lo_byte;
         ADDR_RES_HI: bus_rdata = hi_byte;
         default:     bus_rdata = '0;
      endcase
   end

   assign ctrl_o     = ctrl_q;
   assign chan_run_o = chan_run_q;

   // R9: the latched channel moves only on a start
   a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start_o |=> $stable(chan_run_q));

   // R1: written fields appear at the next edge
   a_r1_field_write: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ctrl_q == $past(bus_wdata[CTRL_W-1:0])));

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int unsigned FIRST_LAT = 5129,
   parameter int unsigned PERIOD    = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic repeat_i,
   output logic busy_o,
   output logic due_o
);

   localparam int unsigned CNT_W = $clog2(FIRST_LAT);
   localparam logic [CNT_W-1:0] LOAD_FIRST  = CNT_W'(FIRST_LAT - 1);
   localparam logic [CNT_W-1:0] LOAD_PERIOD = CNT_W'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("adc_seq_timer: PERIOD must be at least 2");
      end
      if (FIRST_LAT <= PERIOD) begin : g_bad_first
         $error("adc_seq_timer: FIRST_LAT must exceed PERIOD");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   // restart has priority over a completion that falls on the same edge
   assign due_o  = busy_q && (cnt_q == '0) && !start_i;
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD_FIRST;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            if (repeat_i) cnt_q  <= LOAD_PERIOD;
            else          busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // R5: every start reloads the full first-result latency
   a_r5_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy_q && cnt_q == LOAD_FIRST));

   // R11: a start on a due edge suppresses the completion
   a_r11_start_beats_due: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !due_o);

   a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LOAD_FIRST);

endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
   parameter int unsigned SAMPLE_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                due_i,
   input  logic [SAMPLE_W-1:0] samp_i,
   output logic [SAMPLE_W-1:0] result_o,
   output logic                done_o
);

   logic [SAMPLE_W-1:0] result_q;
   logic                done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= due_i;
         if (due_i) result_q <= samp_i;
      end
   end

   assign result_o = result_q;
   assign done_o   = done_q;

   // R3: the result register changes only together with the done strobe
   a_r3_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_q) |-> done_q);

endmodule

// File: rtl/adc_seq_refsel.sv
module adc_seq_refsel
   import adc_seq_pkg::*;
#(
   parameter bit RESERVED_AS_HIGH = 1'b1
) (
   input  logic     ref_hi_i,
   input  logic     ref_lo_i,
   input  logic     pin_drive_i,
   output ref_lvl_e ref_lvl_o,
   output logic     ref_int_en_o,
   output logic     ref_pin_own_o
);

   logic [1:0] code;
   assign code = {ref_hi_i, ref_lo_i};

   generate
      if (RESERVED_AS_HIGH) begin : g_rsv_high
         always_comb begin
            unique case (code)
               2'b00:   ref_lvl_o = REF_EXTERNAL;
               2'b01:   ref_lvl_o = REF_1V0;
               default: ref_lvl_o = REF_2V0;
            endcase
         end
      end else begin : g_rsv_ext
         always_comb begin
            unique case (code)
               2'b01:   ref_lvl_o = REF_1V0;
               2'b10:   ref_lvl_o = REF_2V0;
               default: ref_lvl_o = REF_EXTERNAL;
            endcase
         end
      end
   endgenerate

   assign ref_int_en_o  = (ref_lvl_o != REF_EXTERNAL);
   assign ref_pin_own_o = pin_drive_i;

   // R7: the reserved code never reaches the output
   always_comb a_r7_no_reserved: assert (ref_lvl_o != 2'b11);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned SAMPLE_W         = 10,
   parameter int unsigned FIRST_LAT        = 5129,
   parameter int unsigned PERIOD           = 256,
   parameter bit          RESERVED_AS_HIGH = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          bus_addr,
   input  logic                bus_we,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   input  logic                ref_hi_i,
   input  logic [SAMPLE_W-1:0] samp_i,
   output logic [3:0]          chan_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [SAMPLE_W-1:0] result_o,
   output logic [1:0]          ref_lvl_o,
   output logic                ref_int_en_o,
   output logic                ref_pin_own_o
);

   ctrl_fields_t ctrl;
   logic         start, due, busy;
   ref_lvl_e     lvl;

   adc_seq_regs #(.SAMPLE_W(SAMPLE_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .busy_i     (busy),
      .result_i   (result_o),
      .ctrl_o     (ctrl),
      .start_o    (start),
      .chan_run_o (chan_o)
   );

   adc_seq_timer #(.FIRST_LAT(FIRST_LAT), .PERIOD(PERIOD)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .repeat_i (ctrl.repeat_en),
      .busy_o   (busy),
      .due_o    (due)
   );

   adc_seq_capture #(.SAMPLE_W(SAMPLE_W)) capture_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .due_i    (due),
      .samp_i   (samp_i),
      .result_o (result_o),
      .done_o   (done_o)
   );

   adc_seq_refsel #(.RESERVED_AS_HIGH(RESERVED_AS_HIGH)) refsel_i (
      .ref_hi_i      (ref_hi_i),
      .ref_lo_i      (ctrl.ref_lo),
      .pin_drive_i   (ctrl.pin_drive),
      .ref_lvl_o     (lvl),
      .ref_int_en_o  (ref_int_en_o),
      .ref_pin_own_o (ref_pin_own_o)
   );

   assign ref_lvl_o = lvl;
   assign busy_o    = busy;

   // R3: done is a single-cycle strobe
   a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4: busy drops only on the edge that delivers a result
   a_r4_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R10: in repeat mode a running conversion stays running
   a_r10_repeat_stays_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ctrl.repeat_en) |=> busy_o);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LAT  = 5129;
   localparam int PER  = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ref_hi_i = 1'b0;
   logic [9:0] samp_i = '0;
   logic [3:0] chan_o;
   logic       busy_o, done_o, ref_int_en_o, ref_pin_own_o;
   logic [9:0] result_o;
   logic [1:0] ref_lvl_o;

   int n_vec = 0;
   int n_bad = 0;
   int done_seen = 0;

   adc_seq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_hi_i(ref_hi_i),
      .samp_i(samp_i), .chan_o(chan_o), .busy_o(busy_o), .done_o(done_o),
      .result_o(result_o), .ref_lvl_o(ref_lvl_o),
      .ref_int_en_o(ref_int_en_o), .ref_pin_own_o(ref_pin_own_o));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (rst_n && done_o) done_seen++;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // caller sits just after a falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int v, base;
      idle(2);
      rst_n = 1'b1;
      idle(1);

      // R2 reset state
      rd(2'd0, v); check("R2", "ctrl after reset", v, 0);
      check("R2", "done after reset", int'(done_o), 0);
      check("R2", "result after reset", int'(result_o), 0);
      check("R2", "chan after reset", int'(chan_o), 0);
      rd(2'd3, v); check("R1", "unused address", v, 0);

      // R1 R7 R8 sweep of bits 6:0 and the high reference bit
      for (int c = 0; c < 128; c++) begin
         wr(2'd0, 8'(c));
         rd(2'd0, v); check("R1", "ctrl readback", v, c);
         check("R8", "pin ownership", int'(ref_pin_own_o), (c >> 5) & 1);
         for (int h = 0; h < 2; h++) begin
            int code, lvl;
            ref_hi_i = h[0];
            #1;
            code = h * 2 + ((c >> 6) & 1);
            lvl  = (code == 3) ? 2 : code;
            check("R7", "ref level", int'(ref_lvl_o), lvl);
            check("R7", "internal ref on", int'(ref_int_en_o), (lvl != 0) ? 1 : 0);
         end
      end
      check("R9", "chan untouched without start", int'(chan_o), 0);
      wr(2'd0, 8'h00);

      // R3 R4 single shot
      samp_i = 10'h2A5;
      wr(2'd0, 8'h83);
      check("R9", "chan latched", int'(chan_o), 3);
      idle(LAT - 1);
      check("R3", "no done before latency", int'(done_o), 0);
      rd(2'd0, v); check("R4", "busy bit while running", v, 8'h83);
      idle(1);
      check("R3", "done at latency", int'(done_o), 1);
      check("R3", "result captured", int'(result_o), 10'h2A5);
      rd(2'd1, v); check("R1", "result low byte", v, 8'hA5);
      rd(2'd2, v); check("R1", "result high byte", v, 8'h02);
      rd(2'd0, v); check("R4", "busy bit cleared", v, 8'h03);
      idle(1);
      check("R3", "done one cycle", int'(done_o), 0);

      // R5 restart
      samp_i = 10'h155;
      wr(2'd0, 8'h80);
      idle(1000);
      base = done_seen;
      wr(2'd0, 8'h80);
      idle(LAT - 1);
      check("R5", "old completion dropped", done_seen - base, 0);
      idle(1);
      check("R5", "done after restart latency", int'(done_o), 1);
      check("R5", "result after restart", int'(result_o), 10'h155);

      // R6 R9 write of 0 to start bit while running
      samp_i = 10'h0F0;
      wr(2'd0, 8'h83);
      idle(100);
      wr(2'd0, 8'h45);
      rd(2'd0, v); check("R6", "fields updated, busy kept", v, 8'hC5);
      check("R9", "chan held during run", int'(chan_o), 3);
      idle(LAT - 102);
      check("R6", "no early done", int'(done_o), 0);
      idle(1);
      check("R6", "done on original schedule", int'(done_o), 1);
      check("R6", "result", int'(result_o), 10'h0F0);
      idle(2);

      // R10 repeat mode
      samp_i = 10'h111;
      wr(2'd0, 8'h99);
      check("R9", "new chan latched", int'(chan_o), 9);
      idle(LAT - 1);
      check("R10", "no done before first", int'(done_o), 0);
      idle(1);
      check("R10", "first done", int'(done_o), 1);
      check("R10", "first result", int'(result_o), 10'h111);
      rd(2'd0, v); check("R10", "still busy", v, 8'h99);
      samp_i = 10'h222;
      idle(PER - 1);
      check("R10", "no done before period", int'(done_o), 0);
      idle(1);
      check("R10", "second done", int'(done_o), 1);
      check("R10", "second result", int'(result_o), 10'h222);
      samp_i = 10'h333;
      wr(2'd0, 8'h09);
      idle(PER - 2);
      check("R10", "no done before last", int'(done_o), 0);
      idle(1);
      check("R10", "last done", int'(done_o), 1);
      check("R10", "last result", int'(result_o), 10'h333);
      rd(2'd0, v); check("R10", "busy cleared after last", v, 8'h09);
      base = done_seen;
      idle(600);
      check("R10", "no further updates", done_seen - base, 0);

      // R11 restart on the completion edge
      samp_i = 10'h0AA;
      wr(2'd0, 8'h80);
      idle(LAT - 1);
      samp_i = 10'h3CC;
      wr(2'd0, 8'h80);
      check("R11", "done suppressed", int'(done_o), 0);
      check("R11", "result kept", int'(result_o), 10'h333);
      base = done_seen;
      idle(LAT - 1);
      check("R11", "no done before new latency", done_seen - base, 0);
      idle(1);
      check("R11", "done after new latency", int'(done_o), 1);
      check("R11", "new result", int'(result_o), 10'h3CC);

      idle(3);
      summary();
      $finish;
   end

endmodule